// File: doc/BRIEF.md
# Synchronous Separate-I/O Static RAM with Pass-Through

This block is a single-clock, single-address static memory with one data input bus and a separate data output bus. On every rising clock edge it captures the address, the write data, an active-low write strobe, two chip selects and a bypass request. In the next cycle those captured values drive exactly one access to the array. That access can be a read, or a write that also returns the word it replaces. The result lands in an output register. An asynchronous, active-low output enable then gates the output bus. When it is off, the output bus reads as zero and a drive-enable flag tells the pad logic to float the pins.

The bypass request lets the output show the captured input word instead of the array contents. This is useful when a cell or frame buffer must forward a word in the same slot that it stores it. Reads and writes may alternate on every cycle with no idle slot between them. The word width and the address width are parameters. The default address width of 11 keeps elaboration small, and setting it to 15 gives the full 32768 x 36 organisation.

Top module: `sio_sram`

## Requirements
- R1: A synchronous active-high reset clears the output register to zero and leaves the device deselected, with no write pending. Reset does not alter the array contents.
- R2: Inputs sampled at rising edge n place their read or bypass result on `dout_o` after rising edge n+1, giving a fixed latency of one cycle after capture.
- R3: A selected cycle with `wr_n_i` = 0 stores the captured `din_i` at the captured address. A read of that address sampled at the very next edge returns the new word.
- R4: A selected write cycle is a combined read/write: the output register receives the word the array held at that address before the write.
- R5: When `bypass_i` = 1 is captured in a selected cycle, the output register loads the captured `din_i` instead of the array word. If `wr_n_i` = 0 in the same cycle, the array is still written.
- R6: The device is selected only when `cs_lo_n_i` = 0 and `cs_hi_i` = 1 are captured together. A deselected cycle performs no write and the output register holds its value.
- R7: With `oe_n_i` = 1, `dout_en_o` = 0 and `dout_o` is all zero at once, with no clock edge needed. Returning `oe_n_i` to 0 shows the held register word again.
- R8: Reads and writes may be issued on consecutive cycles in any mix, and each one returns its result with the latency of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write / bypass data |
| wr_n_i | input | 1 | Write strobe, active low |
| cs_lo_n_i | input | 1 | Chip select, active low |
| cs_hi_i | input | 1 | Chip select, active high |
| bypass_i | input | 1 | Route captured input data to the output |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dout_o | output | DATA_W | Registered output word, zero when disabled |
| dout_en_o | output | 1 | High when the output bus should be driven |

## Verification
The bench writes a location and then rewrites it while reading the result. A write-first memory would return the new word at that point instead of the old one. It interleaves writes and reads of the same address on back-to-back cycles. Any extra stage or missing bypass of the array would show up there as stale data or as a result one cycle late. It issues writes with each chip select inactive in turn and checks afterwards that the array and the output are untouched, which catches a decode using only one select. It also checks that reset leaves stored words intact and that the output enable blanks the bus between clock edges.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Decoded control captured at the input edge
  typedef struct packed {
    logic sel;   // both chip selects active
    logic wr;    // write requested
    logic pt;    // bypass requested
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{sel: 1'b0, wr: 1'b0, pt: 1'b0};

endpackage

// File: rtl/sio_in_stage.sv
module sio_in_stage #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   din_i,
  input  logic                wr_n_i,
  input  logic                cs_lo_n_i,
  input  logic                cs_hi_i,
  input  logic                bypass_i,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [DATA_W-1:0]   din_q,
  output sio_pkg::ctrl_t      ctrl_q
);

  // Data path registers carry no reset
  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    din_q  <= din_i;
  end

  // Control registers return to idle on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= sio_pkg::CTRL_IDLE;
    end else begin
      ctrl_q.sel <= ~cs_lo_n_i & cs_hi_i;
      ctrl_q.wr  <= ~wr_n_i;
      ctrl_q.pt  <= bypass_i;
    end
  end

  // R6: select needs both enables at the same edge
  a_r6_select_decode: assert property (@(posedge clk) disable iff (rst)
    (cs_lo_n_i || !cs_hi_i) |=> !ctrl_q.sel);

endmodule

// File: rtl/sio_array.sv
module sio_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: never touched by reset, blocked while reset is high
  always_ff @(posedge clk) begin
    if (en && we && !rst) begin
      mem[addr] <= wdata;
    end
  end

  // Read-first output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (en) begin
      rdata <= mem[addr];
    end
  end

  // R4: read data is the word before this cycle's write
  a_r4_read_old: assert property (@(posedge clk) disable iff (rst)
    en |=> rdata == $past(mem[addr]));

  // R3: write lands at the captured address
  a_r3_write_commit: assert property (@(posedge clk) disable iff (rst)
    (en && we) |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/sio_out_stage.sv
module sio_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                bypass,
  input  logic [DATA_W-1:0]   din,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                oe_n,
  output logic [DATA_W-1:0]   word,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_en
);

  logic              pt_q;
  logic [DATA_W-1:0] byp_q;

  // Bypass flag and word load alongside the array read register
  always_ff @(posedge clk) begin
    if (rst) begin
      pt_q  <= 1'b0;
      byp_q <= '0;
    end else if (en) begin
      pt_q  <= bypass;
      byp_q <= din;
    end
  end

  assign word    = pt_q ? byp_q : rdata;
  assign dout_en = ~oe_n;
  assign dout    = oe_n ? '0 : word;

  // R5: bypass shows the captured input word
  a_r5_bypass_word: assert property (@(posedge clk) disable iff (rst)
    (en && bypass) |=> word == $past(din));

  // R1: the first cycle out of reset shows zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> word == '0);

  // R7: disabled output is blank and undriven
  always_comb begin
    if (oe_n) begin
      a_r7_oe_blank: assert (dout == '0 && !dout_en);
    end
  end

endmodule

// File: rtl/sio_sram.sv
module sio_sram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   din_i,
  input  logic                wr_n_i,
  input  logic                cs_lo_n_i,
  input  logic                cs_hi_i,
  input  logic                bypass_i,
  input  logic                oe_n_i,
  output logic [DATA_W-1:0]   dout_o,
  output logic                dout_en_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  sio_pkg::ctrl_t    ctrl_q;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] word;
  logic              acc_en;
  logic              acc_we;

  assign acc_en = ctrl_q.sel;
  assign acc_we = ctrl_q.sel & ctrl_q.wr;

  sio_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .din_i     (din_i),
    .wr_n_i    (wr_n_i),
    .cs_lo_n_i (cs_lo_n_i),
    .cs_hi_i   (cs_hi_i),
    .bypass_i  (bypass_i),
    .addr_q    (addr_q),
    .din_q     (din_q),
    .ctrl_q    (ctrl_q)
  );

  sio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .en    (acc_en),
    .we    (acc_we),
    .addr  (addr_q),
    .wdata (din_q),
    .rdata (rdata)
  );

  sio_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (acc_en),
    .bypass  (ctrl_q.pt),
    .din     (din_q),
    .rdata   (rdata),
    .oe_n    (oe_n_i),
    .word    (word),
    .dout    (dout_o),
    .dout_en (dout_en_o)
  );

  // R6: a deselected cycle leaves the output word unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(word));

endmodule

// File: tb/test_sio_sram.sv
`timescale 1ns/1ps
module test_sio_sram;

  localparam int AW = 11;
  localparam int DW = 36;
  localparam int MAX_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] din_i = '0;
  logic          wr_n_i = 1'b1;
  logic          cs_lo_n_i = 1'b1;
  logic          cs_hi_i = 1'b0;
  logic          bypass_i = 1'b0;
  logic          oe_n_i = 1'b0;
  logic [DW-1:0] dout_o;
  logic          dout_en_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sio_sram #(.ADDR_W(AW), .DATA_W(DW)) i_sio_sram (
    .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i), .wr_n_i(wr_n_i),
    .cs_lo_n_i(cs_lo_n_i), .cs_hi_i(cs_hi_i), .bypass_i(bypass_i),
    .oe_n_i(oe_n_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                     input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic wn, input logic csn, input logic cs,
                       input logic pt);
    addr_i = a; din_i = d; wr_n_i = wn;
    cs_lo_n_i = csn; cs_hi_i = cs; bypass_i = pt;
  endtask

  task automatic idle();
    drive('0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  // One access, then idle; the result is checked two falling edges later
  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic wn, input logic csn, input logic cs,
                        input logic pt, input bit do_chk,
                        input logic [DW-1:0] exp, input string tag);
    @(negedge clk); drive(a, d, wn, csn, cs, pt);
    @(negedge clk); idle();
    @(negedge clk);
    if (do_chk) chk(dout_o, exp, tag);
  endtask

  task automatic t_reset_state();
    chk(dout_o, '0, "R1 output zero after reset");
    chk({35'd0, dout_en_o}, 36'd1, "R7 driven with oe low");
  endtask

  task automatic t_write_read();
    run_op(11'd3, 36'hC_0000_0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "");
    run_op(11'd7, 36'hC_0000_0002, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "");
    run_op(11'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0001,
           "R2 R3 read of address 3");
    run_op(11'd7, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0002,
           "R2 R3 read of address 7");
  endtask

  task automatic t_combined();
    run_op(11'd3, 36'hC_0000_0003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
           36'hC_0000_0001, "R4 write returns old word");
    run_op(11'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0003,
           "R4 new word stored");
  endtask

  task automatic t_bypass();
    run_op(11'd7, 36'hA_5A5A_5A5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
           36'hA_5A5A_5A5A, "R5 bypass on read");
    run_op(11'd9, 36'h5_1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
           36'h5_1234_5678, "R5 bypass on write");
    run_op(11'd9, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'h5_1234_5678,
           "R5 bypassed write still stored");
    run_op(11'd7, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0002,
           "R5 bypass read left array intact");
  endtask

  task automatic t_select();
    // Output holds C..2 from the last read
    run_op(11'd7, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
           36'hC_0000_0002, "R6 low select off holds output");
    run_op(11'd7, 36'hE_EEEE_EEEE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
           36'hC_0000_0002, "R6 high select off holds output");
    run_op(11'd7, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0002,
           "R6 deselected writes not stored");
  endtask

  task automatic t_back_to_back();
    logic [AW-1:0] a  [6];
    logic [DW-1:0] d  [6];
    logic          wn [6];
    logic [DW-1:0] ex [6];
    bit            ck [6];
    a[0] = 11'd10; d[0] = 36'h0_0000_00E0; wn[0] = 1'b0; ck[0] = 1'b0; ex[0] = '0;
    a[1] = 11'd10; d[1] = '0;              wn[1] = 1'b1; ck[1] = 1'b1; ex[1] = 36'h0_0000_00E0;
    a[2] = 11'd11; d[2] = 36'h0_0000_00E1; wn[2] = 1'b0; ck[2] = 1'b0; ex[2] = '0;
    a[3] = 11'd11; d[3] = '0;              wn[3] = 1'b1; ck[3] = 1'b1; ex[3] = 36'h0_0000_00E1;
    a[4] = 11'd10; d[4] = 36'h0_0000_00E2; wn[4] = 1'b0; ck[4] = 1'b1; ex[4] = 36'h0_0000_00E0;
    a[5] = 11'd10; d[5] = '0;              wn[5] = 1'b1; ck[5] = 1'b1; ex[5] = 36'h0_0000_00E2;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j >= 2 && ck[j-2]) chk(dout_o, ex[j-2], $sformatf("R8 R2 back-to-back op %0d", j-2));
      if (j < 6) drive(a[j], d[j], wn[j], 1'b0, 1'b1, 1'b0);
      else idle();
    end
  endtask

  task automatic t_output_enable();
    @(negedge clk);
    #1 oe_n_i = 1'b1;
    #0.5;
    chk(dout_o, '0, "R7 output blank while disabled");
    chk({35'd0, dout_en_o}, 36'd0, "R7 drive flag low while disabled");
    oe_n_i = 1'b0;
    #0.5;
    chk(dout_o, 36'h0_0000_00E2, "R7 held word returns");
  endtask

  task automatic t_reset_keeps_array();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(dout_o, '0, "R1 reset clears output");
    run_op(11'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 36'hC_0000_0003,
           "R1 array survives reset");
  endtask

  initial begin
    #(MAX_CYCLES * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_write_read();
    t_combined();
    t_bypass();
    t_select();
    t_back_to_back();
    t_output_enable();
    t_reset_keeps_array();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule